// File: doc/BRIEF.md
# Indirect Interrupt-Router Register Window

This block is the software-visible register front end of a 24-input interrupt router. It does not deliver interrupts itself. Software reaches all of its internal registers through a narrow aperture on a simple synchronous bus. First it writes an 8-bit index into a select register. Then it reads or writes a 32-bit data window, and the index chooses which internal word the window exposes.

Behind the window are the following words:
- a router ID register, of which only a 4-bit field is writable;
- a read-only version word;
- a read-only arbitration word that mirrors the ID;
- one 64-bit redirection entry per input pin, split into a low half and a high half.

Each entry holds these fields: vector, delivery mode, destination mode, delivery status, input polarity, remote request flag, trigger mode, mask and destination. The block decodes the fields onto flat output buses for the delivery logic. The delivery logic reports back when it has accepted a level-mode request, and the block then sets that pin's remote request flag.

A separate end-of-interrupt location forwards the low data byte of a write as a one-cycle vector pulse.

Bus reads go through a two-state machine.
- In state IDLE no read data is presented.
- A read request in any state moves the machine to RESPOND ("IDLE to RESPOND", "RESPOND to RESPOND").
- In RESPOND the captured word is presented together with a valid strobe.
- RESPOND returns to IDLE when there is no new read ("RESPOND to IDLE").
- IDLE stays in IDLE while there is no read ("IDLE to IDLE").

Writes commit on the clock edge at which they are presented.

Top module: `irq_router_regfile`

## Requirements
- R1: The select register (bus offset 0x00, written from data bits 7:0 when strobe bit 0 is set) resets to 0x00 and reads back in bits 7:0 exactly the last value written, with bits 31:8 zero.
- R2: Bus offset 0x04 and any offset other than 0x00, 0x10 and 0x40 read as zero. A write to offset 0x04 changes no register.
- R3: Select 0x00 is the ID register. A window write keeps only data bits 27:24, and every other bit reads zero. Select 0x02 reads the same value as the ID register, and a window write to select 0x02 is ignored.
- R4: Select 0x01 reads the version word: (PINS-1) in bits 23:16 and 0x20 in bits 7:0, which is 0x00170020 for 24 pins. Writes to it are ignored.
- R5: Select 0x10+2p addresses bits 31:0 of pin p's entry, and select 0x10+2p+1 addresses bits 63:32. The fields are decoded onto the output buses: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 (1 = level), mask 16, destination 63:56. Bits 55:17 are stored and read back as written.
- R6: After reset every entry reads 0x00010000 in its low half and 0 in its high half, so every pin is masked and all other fields are zero.
- R7: A window write takes effect only when all four byte strobes are set. Any other strobe pattern leaves every register unchanged.
- R8: The delivery status bit (bit 12) is never changed by a low-half write and reads zero.
- R9: The remote request flag (bit 14) is set by an irr_set pulse only while the pin is in level mode. A low-half write that selects level mode keeps the flag whatever data bit 14 holds, and a low-half write that selects edge mode clears it.
- R10: A select value below 0x10 other than 0x00 to 0x02 reads zero and ignores writes. A select value that points past the last pin (0x40 and above for 24 pins) reads 0xFFFFFFFF, and writes through it change no entry.
- R11: A write to offset 0x40 with strobe bit 0 set raises eoi_valid for exactly one cycle, beginning the cycle after the write, with eoi_vector equal to data bits 7:0. Offset 0x40 reads as zero.
- R12: A read presented on one clock edge returns its data on bus_rdata with bus_rvalid high during the following cycle. bus_rvalid is low in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | End-of-interrupt vector |
| irr_set | input | PINS | Per-pin request-accepted pulse from delivery logic |
| ent_vector_o | output | PINS*8 | Vector per pin |
| ent_dlvmode_o | output | PINS*3 | Delivery mode per pin |
| ent_logical_o | output | PINS | Destination mode per pin |
| ent_actlow_o | output | PINS | Polarity per pin |
| ent_level_o | output | PINS | Trigger mode per pin (1 = level) |
| ent_mask_o | output | PINS | Mask per pin |
| ent_irr_o | output | PINS | Remote request flag per pin |
| ent_dest_o | output | PINS*8 | Destination per pin |

## Verification
A table of select and data pairs drives the window through each class of select value: the ID, version and arbitration words, the reserved low indices, the low and high halves of the first, a middle and the last pin, and indices past the last pin. Each pair is followed by a read back, which tells masking, read-only behaviour and entry addressing apart.

Directed sequences then cover the following:
- The remote request flag is built up with irr_set pulses and then rewritten in level mode, under mask and in edge mode. This separates the preserve rule from the clear rule.
- Partial-strobe window writes check that they are dropped.
- Out-of-range writes check that they cannot alias onto pin 0.
- The end-of-interrupt pulse is checked for its one-cycle width.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

    typedef enum logic [2:0] {
        SK_ID,
        SK_VER,
        SK_ARB,
        SK_RSVD,
        SK_ENTRY,
        SK_OOR
    } sel_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    localparam logic [7:0] OFF_SEL    = 8'h00;
    localparam logic [7:0] OFF_SEL_HI = 8'h04;
    localparam logic [7:0] OFF_WIN    = 8'h10;
    localparam logic [7:0] OFF_EOI    = 8'h40;

    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_WIN_BASE = 8'h10;

    localparam logic [7:0] VERSION_CODE = 8'h20;

    localparam int EB_STATUS = 12;
    localparam int EB_IRR    = 14;
    localparam int EB_TRIG   = 15;
    localparam int EB_MASK   = 16;

    localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
    import irq_rf_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int PIN_W = $clog2(PINS)
) (
    input  logic [7:0]       sel,
    output sel_kind_e        kind,
    output logic [PIN_W-1:0] pin,
    output logic             upper
);

    logic [7:0] offs;
    logic [6:0] idx;

    always_comb begin
        offs  = sel - SEL_WIN_BASE;
        idx   = offs[7:1];
        pin   = idx[PIN_W-1:0];
        upper = sel[0];
        if (sel < SEL_WIN_BASE) begin
            unique case (sel)
                SEL_ID:  kind = SK_ID;
                SEL_VER: kind = SK_VER;
                SEL_ARB: kind = SK_ARB;
                default: kind = SK_RSVD;
            endcase
        end else if ({1'b0, idx} < 8'(PINS)) begin
            kind = SK_ENTRY;
        end else begin
            kind = SK_OOR;
        end
    end

endmodule

// File: rtl/irq_rf_table.sv
module irq_rf_table
    import irq_rf_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int PIN_W = $clog2(PINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [PIN_W-1:0]      pin,
    input  logic [31:0]           wdata,
    input  logic [PINS-1:0]       irr_set,
    output logic [PINS-1:0][63:0] ent_q
);

    for (genvar g = 0; g < PINS; g++) begin : g_row
        logic hit;
        assign hit = (pin == PIN_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= ENT_RESET;
            end else if (hit && wr_lo) begin
                ent_q[g][31:16]     <= wdata[31:16];
                ent_q[g][EB_TRIG]   <= wdata[EB_TRIG];
                ent_q[g][EB_IRR]    <= wdata[EB_TRIG] ? ent_q[g][EB_IRR] : 1'b0;
                ent_q[g][13]        <= wdata[13];
                ent_q[g][EB_STATUS] <= ent_q[g][EB_STATUS];
                ent_q[g][11:0]      <= wdata[11:0];
            end else if (hit && wr_hi) begin
                ent_q[g][63:32] <= wdata;
            end else if (irr_set[g] && ent_q[g][EB_TRIG]) begin
                ent_q[g][EB_IRR] <= 1'b1;
            end
        end

        // R9: an edge-mode entry never carries a remote request flag
        assert_edge_no_irr_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !ent_q[g][EB_TRIG] |-> !ent_q[g][EB_IRR]);

        // R8: a low-half write leaves the delivery status bit as it was
        assert_status_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && wr_lo) |=> (ent_q[g][EB_STATUS] == $past(ent_q[g][EB_STATUS])));

        // R9: a level-mode low write keeps the flag
        assert_irr_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && wr_lo && wdata[EB_TRIG]) |=> (ent_q[g][EB_IRR] == $past(ent_q[g][EB_IRR])));
    end

endmodule

// File: rtl/irq_router_regfile.sv
module irq_router_regfile
    import irq_rf_pkg::*;
#(
    parameter int PINS = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_wstrb,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               eoi_valid,
    output logic [7:0]         eoi_vector,
    input  logic [PINS-1:0]    irr_set,
    output logic [PINS*8-1:0]  ent_vector_o,
    output logic [PINS*3-1:0]  ent_dlvmode_o,
    output logic [PINS-1:0]    ent_logical_o,
    output logic [PINS-1:0]    ent_actlow_o,
    output logic [PINS-1:0]    ent_level_o,
    output logic [PINS-1:0]    ent_mask_o,
    output logic [PINS-1:0]    ent_irr_o,
    output logic [PINS*8-1:0]  ent_dest_o
);

    localparam int          PIN_W    = $clog2(PINS);
    localparam logic [7:0]  PIN_MAX  = 8'(PINS - 1);
    localparam logic [31:0] VER_WORD = {8'h00, PIN_MAX, 8'h00, VERSION_CODE};

    bus_state_e            state_q, state_d;
    logic [7:0]            sel_q;
    logic [3:0]            id_q;
    logic [31:0]           rdata_q;
    logic [31:0]           rd_word;
    logic                  eoi_valid_q;
    logic [7:0]            eoi_vec_q;
    sel_kind_e             dec_kind;
    logic [PIN_W-1:0]      dec_pin;
    logic                  dec_upper;
    logic                  win_full;
    logic                  wr_lo, wr_hi;
    logic [PINS-1:0][63:0] ent_q;

    irq_rf_decode #(.PINS(PINS), .PIN_W(PIN_W)) u_decode (
        .sel   (sel_q),
        .kind  (dec_kind),
        .pin   (dec_pin),
        .upper (dec_upper)
    );

    assign win_full = bus_wr && (bus_addr == OFF_WIN) && (bus_wstrb == 4'hF);
    assign wr_lo    = win_full && (dec_kind == SK_ENTRY) && !dec_upper;
    assign wr_hi    = win_full && (dec_kind == SK_ENTRY) &&  dec_upper;

    irq_rf_table #(.PINS(PINS), .PIN_W(PIN_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .pin     (dec_pin),
        .wdata   (bus_wdata),
        .irr_set (irr_set),
        .ent_q   (ent_q)
    );

    // select and identity registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 8'h00;
            id_q  <= 4'h0;
        end else begin
            if (bus_wr && (bus_addr == OFF_SEL) && bus_wstrb[0]) begin
                sel_q <= bus_wdata[7:0];
            end
            if (win_full && (dec_kind == SK_ID)) begin
                id_q <= bus_wdata[27:24];
            end
        end
    end

    // read word selection
    always_comb begin
        rd_word = 32'h0;
        if (bus_addr == OFF_SEL) begin
            rd_word = {24'h0, sel_q};
        end else if (bus_addr == OFF_WIN) begin
            unique case (dec_kind)
                SK_ID, SK_ARB: rd_word = {4'h0, id_q, 24'h0};
                SK_VER:        rd_word = VER_WORD;
                SK_ENTRY:      rd_word = dec_upper ? ent_q[dec_pin][63:32]
                                                   : ent_q[dec_pin][31:0];
                SK_OOR:        rd_word = 32'hFFFF_FFFF;
                default:       rd_word = 32'h0;
            endcase
        end
    end

    // bus state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = bus_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = bus_rd ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // registered data paths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q     <= 32'h0;
            eoi_valid_q <= 1'b0;
            eoi_vec_q   <= 8'h00;
        end else begin
            if (bus_rd) begin
                rdata_q <= rd_word;
            end
            eoi_valid_q <= bus_wr && (bus_addr == OFF_EOI) && bus_wstrb[0];
            if (bus_wr && (bus_addr == OFF_EOI) && bus_wstrb[0]) begin
                eoi_vec_q <= bus_wdata[7:0];
            end
        end
    end

    // outputs
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = 32'h0;
        unique case (state_q)
            ST_IDLE: begin
                bus_rvalid = 1'b0;
                bus_rdata  = 32'h0;
            end
            ST_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            default: begin
                bus_rvalid = 1'b0;
                bus_rdata  = 32'h0;
            end
        endcase
        eoi_valid  = eoi_valid_q;
        eoi_vector = eoi_vec_q;
    end

    for (genvar p = 0; p < PINS; p++) begin : g_fields
        assign ent_vector_o[p*8 +: 8]  = ent_q[p][7:0];
        assign ent_dlvmode_o[p*3 +: 3] = ent_q[p][10:8];
        assign ent_logical_o[p]        = ent_q[p][11];
        assign ent_actlow_o[p]         = ent_q[p][13];
        assign ent_irr_o[p]            = ent_q[p][EB_IRR];
        assign ent_level_o[p]          = ent_q[p][EB_TRIG];
        assign ent_mask_o[p]           = ent_q[p][EB_MASK];
        assign ent_dest_o[p*8 +: 8]    = ent_q[p][63:56];
    end

    // R11: one-cycle end-of-interrupt pulse carrying the written byte
    assert_eoi_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFF_EOI) && bus_wstrb[0])
            |=> (eoi_valid && (eoi_vector == $past(bus_wdata[7:0]))));

    assert_eoi_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == OFF_EOI) && bus_wstrb[0]) |=> !eoi_valid);

    // R12: read data valid in the cycle after a read
    assert_rvalid_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_rvalid_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R1: select register takes the written byte
    assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFF_SEL) && bus_wstrb[0]) |=> (sel_q == $past(bus_wdata[7:0])));

    // R7: partial-strobe window writes leave the table untouched
    assert_partial_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFF_WIN) && (bus_wstrb != 4'hF) && (irr_set == '0))
            |=> $stable(ent_q));

    // R10: writes through an out-of-range select change no entry
    assert_oor_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_full && (dec_kind == SK_OOR) && (irr_set == '0)) |=> $stable(ent_q));

endmodule

// File: tb/irq_router_regfile_bench.sv
module irq_router_regfile_bench;

    localparam int PINS = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = 8'h00;
    logic [31:0]       bus_wdata = 32'h0;
    logic [3:0]        bus_wstrb = 4'h0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              eoi_valid;
    logic [7:0]        eoi_vector;
    logic [PINS-1:0]   irr_set = '0;
    logic [PINS*8-1:0] ent_vector_o;
    logic [PINS*3-1:0] ent_dlvmode_o;
    logic [PINS-1:0]   ent_logical_o;
    logic [PINS-1:0]   ent_actlow_o;
    logic [PINS-1:0]   ent_level_o;
    logic [PINS-1:0]   ent_mask_o;
    logic [PINS-1:0]   ent_irr_o;
    logic [PINS*8-1:0] ent_dest_o;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    irq_router_regfile #(.PINS(PINS)) u_irq_router_regfile (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_wstrb     (bus_wstrb),
        .bus_rdata     (bus_rdata),
        .bus_rvalid    (bus_rvalid),
        .eoi_valid     (eoi_valid),
        .eoi_vector    (eoi_vector),
        .irr_set       (irr_set),
        .ent_vector_o  (ent_vector_o),
        .ent_dlvmode_o (ent_dlvmode_o),
        .ent_logical_o (ent_logical_o),
        .ent_actlow_o  (ent_actlow_o),
        .ent_level_o   (ent_level_o),
        .ent_mask_o    (ent_mask_o),
        .ent_irr_o     (ent_irr_o),
        .ent_dest_o    (ent_dest_o)
    );

    // {select, write value, expected read back}
    localparam logic [71:0] VEC [12] = '{
        {8'h00, 32'h1F3E_5D7C, 32'h0F00_0000},   // R3 ID keeps 27:24
        {8'h02, 32'hFFFF_FFFF, 32'h0F00_0000},   // R3 arbitration mirrors ID
        {8'h01, 32'hFFFF_FFFF, 32'h0017_0020},   // R4 version read-only
        {8'h05, 32'h1234_5678, 32'h0000_0000},   // R10 reserved low select
        {8'h0F, 32'hFFFF_FFFF, 32'h0000_0000},   // R10 reserved low select
        {8'h10, 32'h0001_0B3A, 32'h0001_0B3A},   // R5 pin 0 low
        {8'h11, 32'h5F00_0000, 32'h5F00_0000},   // R5 pin 0 high
        {8'h2F, 32'hA500_0001, 32'hA500_0001},   // R5 pin 15 high, reserved kept
        {8'h3E, 32'h0000_9041, 32'h0000_8041},   // R8 pin 23 low, status dropped
        {8'h40, 32'hDEAD_BEEF, 32'hFFFF_FFFF},   // R10 past last pin
        {8'hFF, 32'hDEAD_BEEF, 32'hFFFF_FFFF},   // R10 past last pin
        {8'h10, 32'h0000_5000, 32'h0000_0000}    // R9 edge write clears flag
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [31:0] data,
                             input logic [3:0] strb);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = addr;
        bus_wdata = data;
        bus_wstrb = strb;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wstrb = 4'h0;
    endtask

    task automatic bus_read(input logic [7:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = addr;
        @(negedge clk);
        bus_rd = 1'b0;
        data   = bus_rdata;
        check(bus_rvalid === 1'b1, "R12 rvalid after read", {31'h0, bus_rvalid}, 32'h1);
    endtask

    task automatic reg_write(input logic [7:0] sel, input logic [31:0] data);
        bus_write(8'h00, {24'h0, sel}, 4'h1);
        bus_write(8'h10, data, 4'hF);
    endtask

    task automatic reg_read(input logic [7:0] sel, output logic [31:0] data);
        bus_write(8'h00, {24'h0, sel}, 4'h1);
        bus_read(8'h10, data);
    endtask

    task automatic pulse_irr(input int p);
        @(negedge clk);
        irr_set = PINS'(1) << p;
        @(negedge clk);
        irr_set = '0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(bus_rvalid === 1'b0, "R12 rvalid idle after reset", {31'h0, bus_rvalid}, 32'h0);
        check(eoi_valid === 1'b0, "R11 eoi idle after reset", {31'h0, eoi_valid}, 32'h0);
        check(ent_mask_o === '1, "R6 all pins masked", 32'(ent_mask_o), 32'(24'hFFFFFF));
        check(ent_vector_o === '0, "R6 vectors zero", ent_vector_o[31:0], 32'h0);
        bus_read(8'h00, rv);
        check(rv === 32'h0, "R1 select resets to zero", rv, 32'h0);
        reg_read(8'h1A, rv);
        check(rv === 32'h0001_0000, "R6 pin 5 low reset", rv, 32'h0001_0000);
        reg_read(8'h1B, rv);
        check(rv === 32'h0, "R6 pin 5 high reset", rv, 32'h0);

        // vector table
        for (int i = 0; i < 12; i++) begin
            reg_write(VEC[i][71:64], VEC[i][63:32]);
            reg_read(VEC[i][71:64], rv);
            check(rv === VEC[i][31:0], $sformatf("R5 table row %0d", i), rv, VEC[i][31:0]);
        end

        // R5 decoded fields
        check(ent_dest_o[7:0] === 8'h5F, "R5 pin 0 destination", 32'(ent_dest_o[7:0]), 32'h5F);
        check(ent_dest_o[15*8 +: 8] === 8'hA5, "R5 pin 15 destination",
              32'(ent_dest_o[15*8 +: 8]), 32'hA5);
        check(ent_level_o[23] === 1'b1, "R5 pin 23 level", 32'(ent_level_o[23]), 32'h1);
        check(ent_vector_o[23*8 +: 8] === 8'h41, "R5 pin 23 vector",
              32'(ent_vector_o[23*8 +: 8]), 32'h41);
        check(ent_mask_o[23] === 1'b0, "R5 pin 23 unmasked", 32'(ent_mask_o[23]), 32'h0);
        reg_write(8'h12, 32'h0000_2B77);
        check(ent_dlvmode_o[3 +: 3] === 3'h3 && ent_logical_o[1] === 1'b1 &&
              ent_actlow_o[1] === 1'b1, "R5 pin 1 mode fields",
              {24'h0, ent_actlow_o[1], ent_logical_o[1], 3'h0, ent_dlvmode_o[3 +: 3]}, 32'hC3);

        // R1 select readback and R2 offset 0x04
        bus_write(8'h00, 32'hFFFF_FF33, 4'h1);
        bus_write(8'h04, 32'h0000_00AA, 4'hF);
        bus_read(8'h00, rv);
        check(rv === 32'h33, "R1 select readback / R2 0x04 write ignored", rv, 32'h33);
        bus_read(8'h04, rv);
        check(rv === 32'h0, "R2 offset 0x04 reads zero", rv, 32'h0);
        bus_read(8'h20, rv);
        check(rv === 32'h0, "R2 unmapped offset reads zero", rv, 32'h0);
        @(negedge clk);
        check(bus_rvalid === 1'b0, "R12 rvalid drops", {31'h0, bus_rvalid}, 32'h0);

        // R7 partial strobes
        bus_write(8'h00, 32'h14, 4'h1);
        bus_write(8'h10, 32'h0000_0077, 4'h7);
        bus_write(8'h10, 32'h0000_0077, 4'h1);
        bus_read(8'h10, rv);
        check(rv === 32'h0001_0000, "R7 partial window write dropped", rv, 32'h0001_0000);
        bus_write(8'h00, 32'h00, 4'h1);
        bus_write(8'h10, 32'h0F00_0000, 4'hE);
        bus_read(8'h10, rv);
        check(rv === 32'h0F00_0000, "R7 partial ID write dropped", rv, 32'h0F00_0000);

        // R9 remote request flag
        reg_write(8'h16, 32'h0000_8022);
        pulse_irr(3);
        reg_read(8'h16, rv);
        check(rv === 32'h0000_C022, "R9 flag set in level mode", rv, 32'h0000_C022);
        check(ent_irr_o[3] === 1'b1, "R9 flag output", 32'(ent_irr_o[3]), 32'h1);
        reg_write(8'h16, 32'h0000_8023);
        reg_read(8'h16, rv);
        check(rv === 32'h0000_C023, "R9 level write keeps flag", rv, 32'h0000_C023);
        reg_write(8'h16, 32'h0001_8023);
        reg_read(8'h16, rv);
        check(rv === 32'h0001_C023, "R9 masking keeps flag", rv, 32'h0001_C023);
        reg_write(8'h17, 32'h1100_0000);
        reg_read(8'h16, rv);
        check(rv === 32'h0001_C023, "R9 high write keeps flag", rv, 32'h0001_C023);
        reg_write(8'h16, 32'h0000_4023);
        reg_read(8'h16, rv);
        check(rv === 32'h0000_0023, "R9 edge write clears flag", rv, 32'h0000_0023);
        pulse_irr(3);
        reg_read(8'h16, rv);
        check(rv === 32'h0000_0023, "R9 no flag in edge mode", rv, 32'h0000_0023);

        // R10 out-of-range writes do not alias
        reg_write(8'h40, 32'h1234_5678);
        reg_write(8'h41, 32'h9900_0000);
        reg_read(8'h10, rv);
        check(rv === 32'h0, "R10 pin 0 low untouched", rv, 32'h0);
        reg_read(8'h11, rv);
        check(rv === 32'h5F00_0000, "R10 pin 0 high untouched", rv, 32'h5F00_0000);

        // R11 end of interrupt
        bus_write(8'h40, 32'h1234_56C7, 4'hF);
        check(eoi_valid === 1'b1 && eoi_vector === 8'hC7, "R11 eoi pulse",
              {23'h0, eoi_valid, eoi_vector}, 32'h1C7);
        @(negedge clk);
        check(eoi_valid === 1'b0, "R11 eoi one cycle", {31'h0, eoi_valid}, 32'h0);
        bus_read(8'h40, rv);
        check(rv === 32'h0, "R11 eoi offset reads zero", rv, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule